// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Modem Handshake

This block serialises characters onto a single output line in asynchronous format. Each character is written into a one-entry holding buffer. On a bit-cell boundary the buffer moves into a shift register, which then sends one bit per bit cell. The bit cells are marked by a single-cycle clock-enable pulse, `bit_tick`, that the surrounding logic supplies.

Software-style control inputs set the following:
- the character length, from 5 to 8 data bits;
- whether a parity bit is added, and whether it gives even or odd parity;
- a break request that forces the line low;
- the request-to-send bit;
- the transmit enable;
- an auto-enables mode.

In auto-enables mode, the clear-to-send input gates the start of each character. The request-to-send pin is also held active until the last stop bit has left the line.

Top module: `serial_char_tx`

## Requirements
- R1: A frame is a start bit of 0, then the data bits least significant bit first, then the optional parity bit, then one stop bit of 1. Each bit occupies one bit cell, and a new bit appears on `txd` after the clock edge on which `bit_tick` is 1. When nothing is being sent, `txd` is 1.
- R2: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The value is sampled on the bit cell that moves the holding buffer into the shift register. A later change does not alter the character already in the shift register.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_even` = 1, the number of ones in the data bits plus the parity bit is even. With `cfg_par_even` = 0, that number is odd.
- R4: After `cfg_break` is set, `txd` is 0 from the first bit-cell edge onwards. Before that edge, `txd` keeps its value. This also holds when `cfg_tx_en` is 0.
- R5: While break is active, the character in progress is suspended. At the first bit-cell edge after `cfg_break` clears, `txd` again shows the bit that was on the line when the break began. The rest of the character then follows.
- R6: While `cfg_tx_en` is 0, a written character stays in the holding buffer and no start bit is sent.
- R7: With `cfg_auto` = 1 and `cfg_tx_en` = 1, a high `cts_pin` keeps the next character from starting. A low `cts_pin` lets it start. The gate is checked only at character start, so a character already begun is sent in full.
- R8: With `cfg_auto` = 0, `rts_pin` is the inverse of `cfg_rts`.
- R9: With `cfg_auto` = 1, after `cfg_rts` goes from 1 to 0, `rts_pin` stays 0 until `all_sent` is 1, and then goes to 1.
- R10: `cts_stat` equals the value `cts_pin` had one clock earlier.
- R11: `buf_empty` is 1 after reset and after the holding buffer moves into the shift register, and 0 after a data write. `all_sent` is 1 only when the holding buffer is empty and the stop bit's cell has ended. It stays 0 while the stop bit is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse at each bit-cell boundary |
| cfg_len | input | 2 | Character length select (5 + value data bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_break | input | 1 | Force the line low from the next bit cell |
| cfg_rts | input | 1 | Request-to-send control bit |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_auto | input | 1 | Auto-enables mode |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | MAX_BITS | Character to send |
| cts_pin | input | 1 | Clear-to-send input |
| txd | output | 1 | Serial data line |
| rts_pin | output | 1 | Request-to-send output, active low |
| cts_stat | output | 1 | Registered copy of `cts_pin` |
| buf_empty | output | 1 | Holding buffer is empty |
| all_sent | output | 1 | Buffer and shift register empty, last stop bit done |

## Verification
Break is hardest to reach: the bench has to land it inside a character, with a bit that differs from 0 on the line, to show both the suspension and the resumption of that same bit. It first clocks three bit cells of a chosen character, so that a 1 is on the line. It then raises break between edges and samples `txd` before and after the next edge, holds break for two cells, and clears it. Finally it checks that the following cell shows the same 1 and that the remaining bits come in order. A second awkward case is the auto-enables release of request-to-send. Here `cfg_rts` is dropped just after a character has started, and the pin is watched through the stop cell and the cell that follows it.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    // Width of the character-length select field.
    localparam int SCTX_LEN_W = 2;

    // Registered state of the modem-control logic.
    typedef struct packed {
        logic keep;   // request-to-send was recently active
        logic cts;    // synchronised clear-to-send
    } sctx_modem_t;

endpackage

// File: rtl/sctx_framer.sv
module sctx_framer #(
    parameter int MAX_BITS = 8,
    parameter int FRAME_W  = MAX_BITS + 2,
    parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
    input  logic [MAX_BITS-1:0]             data,
    input  logic [sctx_pkg::SCTX_LEN_W-1:0] len_sel,
    input  logic                            par_en,
    input  logic                            par_even,
    output logic [FRAME_W-1:0]              frame,
    output logic [CNT_W-1:0]                nbits
);
    localparam int MIN_LEN = MAX_BITS - 3;

    int                 len_int;
    logic               par_bit;
    logic [FRAME_W-1:0] dext;

    assign len_int = MIN_LEN + int'(len_sel);
    assign dext    = {{(FRAME_W-MAX_BITS){1'b0}}, data};

    // Parity over the data bits that belong to the selected length.
    always_comb begin
        logic ones;
        ones = 1'b0;
        for (int k = 0; k < MAX_BITS; k++) begin
            if (k < len_int) ones = ones ^ data[k];
        end
        par_bit = par_even ? ones : ~ones;
    end

    // Bits that follow the start bit: data, optional parity, then stop (1).
    for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
        assign frame[i] = (i < len_int) ? dext[i]
                        : ((i == len_int && par_en) ? par_bit : 1'b1);
    end

    assign nbits = CNT_W'(len_int + int'(par_en) + 1);

endmodule

// File: rtl/sctx_modem.sv
module sctx_modem (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_rts,
    input  logic cfg_auto,
    input  logic cfg_tx_en,
    input  logic cts_pin,
    input  logic all_sent,
    output logic rts_pin,
    output logic cts_stat,
    output logic start_ok
);
    import sctx_pkg::*;

    sctx_modem_t m_d, m_q;
    logic        rts_active;

    assign rts_active = cfg_rts | (m_q.keep & cfg_auto & ~all_sent);

    always_comb begin
        m_d      = m_q;
        m_d.keep = rts_active;
        m_d.cts  = cts_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign rts_pin  = ~rts_active;
    assign cts_stat = m_q.cts;
    assign start_ok = cfg_tx_en & ~(cfg_auto & m_q.cts);

    // R8: the RTS bit set always drives the pin active (low)
    a_r8_rts_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rts |-> !rts_pin);

    // R9: under auto-enables, dropping RTS keeps the pin low while data remains
    a_r9_rts_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto && $fell(cfg_rts) && !all_sent) |-> !rts_pin);

    // R10: status bit follows the pin one clock later
    a_r10_cts_status: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cts_stat == $past(cts_pin)));

endmodule

// File: rtl/sctx_shifter.sv
module sctx_shifter #(
    parameter int MAX_BITS = 8,
    parameter int FRAME_W  = MAX_BITS + 2,
    parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cfg_break,
    input  logic                start_ok,
    input  logic                wr_stb,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic [FRAME_W-1:0]  frame,
    input  logic [CNT_W-1:0]    nbits,
    output logic [MAX_BITS-1:0] hold_data,
    output logic                txd_o,
    output logic                buf_empty,
    output logic                all_sent
);
    typedef struct packed {
        logic                line;
        logic                brk;
        logic                busy;
        logic                hold_full;
        logic [MAX_BITS-1:0] hold;
        logic [FRAME_W-1:0]  shift;
        logic [CNT_W-1:0]    left;
    } shift_st_t;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    shift_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (cfg_break) begin
                s_d.brk = 1'b1;
            end else if (s_q.brk) begin
                s_d.brk = 1'b0;
            end else if (s_q.busy && s_q.left != '0) begin
                s_d.line  = s_q.shift[0];
                s_d.shift = {1'b1, s_q.shift[FRAME_W-1:1]};
                s_d.left  = s_q.left - ONE;
            end else begin
                s_d.busy = 1'b0;
                s_d.line = 1'b1;
                if (s_q.hold_full && start_ok) begin
                    s_d.line      = 1'b0;
                    s_d.shift     = frame;
                    s_d.left      = nbits;
                    s_d.busy      = 1'b1;
                    s_d.hold_full = 1'b0;
                end
            end
        end
        if (wr_stb) begin
            s_d.hold      = wr_data;
            s_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{line: 1'b1, default: '0};
        else        s_q <= s_d;
    end

    assign hold_data = s_q.hold;
    assign txd_o     = s_q.brk ? 1'b0 : s_q.line;
    assign buf_empty = ~s_q.hold_full;
    assign all_sent  = ~s_q.busy & ~s_q.hold_full;

    // R1: idle line is high when no break is active
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !s_q.brk) |-> txd_o);

    // R4: break pulls the line low from the next bit cell
    a_r4_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_break) |=> !txd_o);

    // R5: clearing break shows again the bit held before the break
    a_r5_resume_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cfg_break && s_q.brk) |=> (txd_o == $past(s_q.line)));

    // R6 and R7: a blocked start keeps the shift register idle
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !start_ok) |=> !s_q.busy);

    // R11: a transfer empties the buffer and puts a start bit on the line
    a_r11_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cfg_break && !s_q.brk && !s_q.busy && s_q.hold_full
         && start_ok && !wr_stb) |=> (buf_empty && !txd_o && !all_sent));

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
    parameter int MAX_BITS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bit_tick,
    input  logic [sctx_pkg::SCTX_LEN_W-1:0] cfg_len,
    input  logic                            cfg_par_en,
    input  logic                            cfg_par_even,
    input  logic                            cfg_break,
    input  logic                            cfg_rts,
    input  logic                            cfg_tx_en,
    input  logic                            cfg_auto,
    input  logic                            wr_stb,
    input  logic [MAX_BITS-1:0]             wr_data,
    input  logic                            cts_pin,
    output logic                            txd,
    output logic                            rts_pin,
    output logic                            cts_stat,
    output logic                            buf_empty,
    output logic                            all_sent
);
    localparam int FRAME_W = MAX_BITS + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [MAX_BITS-1:0] hold_data;
    logic [FRAME_W-1:0]  frame;
    logic [CNT_W-1:0]    nbits;
    logic                start_ok;
    logic                sent_w;

    sctx_framer #(.MAX_BITS(MAX_BITS), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data     (hold_data),
        .len_sel  (cfg_len),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .frame    (frame),
        .nbits    (nbits)
    );

    sctx_shifter #(.MAX_BITS(MAX_BITS), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .cfg_break (cfg_break),
        .start_ok  (start_ok),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .frame     (frame),
        .nbits     (nbits),
        .hold_data (hold_data),
        .txd_o     (txd),
        .buf_empty (buf_empty),
        .all_sent  (sent_w)
    );

    sctx_modem u_modem (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rts   (cfg_rts),
        .cfg_auto  (cfg_auto),
        .cfg_tx_en (cfg_tx_en),
        .cts_pin   (cts_pin),
        .all_sent  (sent_w),
        .rts_pin   (rts_pin),
        .cts_stat  (cts_stat),
        .start_ok  (start_ok)
    );

    assign all_sent = sent_w;

endmodule

// File: tb/test_serial_char_tx.sv
module test_serial_char_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_break = 1'b0;
    logic       cfg_rts = 1'b0;
    logic       cfg_tx_en = 1'b1;
    logic       cfg_auto = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cts_pin = 1'b0;
    logic       txd, rts_pin, cts_stat, buf_empty, all_sent;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_char_tx #(.MAX_BITS(8)) i_serial_char_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_break(cfg_break),
        .cfg_rts(cfg_rts), .cfg_tx_en(cfg_tx_en), .cfg_auto(cfg_auto),
        .wr_stb(wr_stb), .wr_data(wr_data), .cts_pin(cts_pin), .txd(txd),
        .rts_pin(rts_pin), .cts_stat(cts_stat), .buf_empty(buf_empty), .all_sent(all_sent)
    );

    // Whole frame as it appears on the line, bit 0 first.
    function automatic logic [11:0] exp_frame(input logic [7:0] d, input int len,
                                              input bit pe, input bit ev, output int n);
        logic [11:0] f;
        int          p;
        bit          x;
        f = '1; f[0] = 1'b0; x = 1'b0; p = 1;
        for (int i = 0; i < len; i++) begin
            f[p] = d[i]; x = x ^ d[i]; p++;
        end
        if (pe) begin
            f[p] = ev ? x : ~x; p++;
        end
        f[p] = 1'b1;
        n = p + 1;
        return f;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 20 && !all_sent; k++) tick();
    endtask

    // Sends one character, collects the line and checks it bit by bit.
    task automatic send_frame(input logic [7:0] d, input logic [1:0] ls, input bit pe,
                              input bit ev, input string req, input int len_after);
        logic [11:0] f, got;
        int          n;
        @(negedge clk) begin cfg_len = ls; cfg_par_en = pe; cfg_par_even = ev; end
        write(d);
        chk({req, " buf_empty low after write (R11)"}, int'(buf_empty), 0);
        f   = exp_frame(d, 5 + int'(ls), pe, ev, n);
        got = '1;
        for (int i = 0; i < n; i++) begin
            tick();
            got[i] = txd;
            if (i == 0) begin
                chk({req, " buf_empty after transfer (R11)"}, int'(buf_empty), 1);
                if (len_after >= 0) cfg_len = 2'(len_after);
            end
        end
        chk({req, " frame bits (R1)"}, int'(got), int'(f));
        chk({req, " all_sent low on stop cell (R11)"}, int'(all_sent), 0);
        tick();
        chk({req, " all_sent after stop (R11)"}, int'(all_sent), 1);
        chk({req, " line idle after frame (R1)"}, int'(txd), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] f, got;
        int          n;
        int          seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R11 reset buf_empty", int'(buf_empty), 1);
        chk("R11 reset all_sent", int'(all_sent), 1);
        chk("R8 reset rts_pin", int'(rts_pin), 1);

        // R1, R3 directed frames
        send_frame(8'hA5, 2'd3, 1'b0, 1'b0, "R1 8N", -1);
        send_frame(8'h07, 2'd3, 1'b1, 1'b1, "R3 even", -1);
        send_frame(8'h07, 2'd3, 1'b1, 1'b0, "R3 odd", -1);
        send_frame(8'h1B, 2'd0, 1'b1, 1'b1, "R3 5bit even", -1);
        // R2 length latched at transfer
        send_frame(8'h00, 2'd0, 1'b0, 1'b0, "R2 latch short", 3);
        send_frame(8'hD3, 2'd3, 1'b1, 1'b0, "R2 latch long", 0);
        send_frame(8'h2A, 2'd1, 1'b0, 1'b0, "R2 six bits", -1);
        send_frame(8'h55, 2'd2, 1'b1, 1'b0, "R2 seven bits", -1);

        // R4, R5 break inside a character
        @(negedge clk) begin cfg_len = 2'd3; cfg_par_en = 1'b0; end
        write(8'hA7);
        f = exp_frame(8'hA7, 8, 1'b0, 1'b0, n);
        repeat (3) tick();
        chk("R1 bit before break", int'(txd), int'(f[2]));
        cfg_break = 1'b1;
        @(negedge clk);
        chk("R4 no change before bit edge", int'(txd), 1);
        tick();
        chk("R4 break low first cell", int'(txd), 0);
        tick();
        chk("R4 break low second cell", int'(txd), 0);
        cfg_break = 1'b0;
        @(negedge clk);
        chk("R5 still low before bit edge", int'(txd), 0);
        tick();
        chk("R5 resumed bit", int'(txd), int'(f[2]));
        got = '1;
        for (int i = 3; i < n; i++) begin
            tick();
            got[i] = txd;
        end
        chk("R5 remainder after break", int'(got[11:3]), int'(f[11:3]));
        tick();
        chk("R5 all_sent after resumed frame", int'(all_sent), 1);

        // R4 break while disabled
        cfg_tx_en = 1'b0;
        cfg_break = 1'b1;
        tick();
        chk("R4 break with enable off", int'(txd), 0);
        cfg_break = 1'b0;
        tick();
        chk("R4 idle after break cleared", int'(txd), 1);

        // R6 enable off holds the character
        write(8'h3C);
        repeat (3) tick();
        chk("R6 no start while disabled", int'(txd), 1);
        chk("R6 buffer kept while disabled", int'(buf_empty), 0);
        cfg_tx_en = 1'b1;
        tick();
        chk("R6 start after enable", int'(txd), 0);
        drain();
        chk("R6 drained", int'(all_sent), 1);

        // R10 status follows the pin
        cts_pin = 1'b1;
        @(negedge clk);
        chk("R10 cts_stat high", int'(cts_stat), 1);
        cts_pin = 1'b0;
        @(negedge clk);
        chk("R10 cts_stat low", int'(cts_stat), 0);

        // R7 auto-enables gating
        cfg_auto = 1'b1;
        cts_pin = 1'b1;
        repeat (2) @(negedge clk);
        write(8'h3C);
        f = exp_frame(8'h3C, 8, 1'b0, 1'b0, n);
        repeat (3) tick();
        chk("R7 CTS high blocks start", int'(txd), 1);
        chk("R7 buffer kept while blocked", int'(buf_empty), 0);
        cts_pin = 1'b0;
        repeat (2) @(negedge clk);
        tick();
        chk("R7 start after CTS low", int'(txd), 0);
        cts_pin = 1'b1;
        got = '1; got[0] = 1'b0;
        for (int i = 1; i < n; i++) begin
            tick();
            got[i] = txd;
        end
        chk("R7 started frame completes", int'(got), int'(f));
        tick();
        chk("R7 all_sent after frame", int'(all_sent), 1);
        cts_pin = 1'b0;
        repeat (2) @(negedge clk);

        // R9 auto-enables holds RTS until the line is done
        cfg_rts = 1'b1;
        @(negedge clk);
        chk("R9 rts active", int'(rts_pin), 0);
        @(negedge clk) begin cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b1; end
        write(8'h55);
        tick();
        cfg_rts = 1'b0;
        @(negedge clk);
        chk("R9 rts held after bit cleared", int'(rts_pin), 0);
        repeat (7) tick();
        chk("R9 rts held on stop cell", int'(rts_pin), 0);
        chk("R9 not yet all_sent", int'(all_sent), 0);
        tick();
        chk("R9 rts released after stop", int'(rts_pin), 1);

        // R8 plain mode follows the bit immediately
        cfg_auto = 1'b0;
        cfg_rts = 1'b1;
        @(negedge clk);
        chk("R8 rts active", int'(rts_pin), 0);
        write(8'h81);
        tick();
        cfg_rts = 1'b0;
        @(negedge clk);
        chk("R8 rts follows bit mid-frame", int'(rts_pin), 1);
        drain();

        // Constrained random frames
        seed = int'($urandom(32'd20240));
        for (int t = 0; t < 40; t++) begin
            logic [7:0] d;
            logic [1:0] ls;
            bit         pe, ev;
            d  = 8'($urandom);
            ls = 2'($urandom % 4);
            pe = 1'($urandom % 2);
            ev = 1'($urandom % 2);
            send_frame(d, ls, pe, ev, "R1 R2 R3 random", -1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule